// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects ten interrupt requests for a small 8-bit processor core, picks one, and hands the core the address of its service routine. Six requests come from external pins. Two of them, ext0 and ext1, can be set to level or edge sensing. The other four, ext2 to ext5, always sense an edge. The remaining requests are three timer overflow flags and a serial request. The serial request is the OR of a transmit-done flag and a receive-done flag. Software gives each source an enable bit and a one-bit priority. A global enable gates every source.

Only one request is offered to the core at a time, over a valid/ready pair. `irq_req` is the valid signal and `irq_ack` is the ready signal. Once `irq_req` rises, the offered vector is frozen and cannot be replaced, even by a more urgent request, until the core accepts it. An accepted vector marks its priority level as in service. `irq_ret` closes the innermost level that is in service. A low-priority handler can therefore be interrupted by a high-priority request, and a high-priority handler cannot be interrupted at all.

A separate `wake` output reports that one of the four edge-only inputs has a pending, enabled event. It ignores the global enable, so it can restart a core whose clocks are stopped.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Source indices and vectors are fixed. Index 0 is ext0 at 8'h03, 1 is timer0 at 8'h0B, 2 is ext1 at 8'h13, 3 is timer1 at 8'h1B, 4 is serial at 8'h23, 5 is timer2 at 8'h2B, 6 is ext2 at 8'h43, 7 is ext3 at 8'h4B, 8 is ext4 at 8'h53 and 9 is ext5 at 8'h5B.
- R2: Among eligible requests at the same priority level, the lowest index wins.
- R3: An eligible request with its priority bit set (1 = high) beats every low-priority request.
- R4: While a high-priority vector is in service, no request is offered. While only a low-priority vector is in service, only high-priority requests are offered.
- R5: A pulse on `irq_ret` closes the high level if it is in service, and otherwise closes the low level. Requests that the closed level was blocking become eligible again.
- R6: Each external pin passes through two synchronizer flops before edge detection. ext2 and ext4 detect rising edges. ext3 and ext5 detect falling edges. ext0 and ext1 detect falling edges when their mode bit is 1. An edge made at a pin before clock edge E0 sets `irq_req` after edge E3 and not before. An edge of the opposite polarity sets nothing.
- R7: With its mode bit at 0, ext0 or ext1 requests for as long as its synchronized pin is low. Acceptance does not clear the request.
- R8: Acceptance clears the pending flag of an edge source. If a new edge sets the same flag in the same cycle, the set wins.
- R9: Timer and serial requests are level flags owned by the peripherals. Acceptance does not clear them.
- R10: A request counts only when its source enable bit and `glob_en` are both 1. Edge pending flags latch even while the request is disabled, and they request once it is enabled.
- R11: While `irq_req` is high and `irq_ack` is low, `irq_req` stays high and `irq_vec` holds its value.
- R12: `wake` is 1 one cycle after any of ext2 to ext5 has both its pending flag and its source enable set, whatever the value of `glob_en`.
- R13: After reset, `irq_req` and `wake` are 0 and no level is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin | input | 6 | Raw external interrupt pins ext0 to ext5 |
| ext01_edge | input | 2 | Sensing mode for ext0 and ext1: 1 = falling edge, 0 = low level |
| tmr_ovf | input | 3 | Overflow flags of timer0, timer1 and timer2 |
| ser_tx_done | input | 1 | Serial transmit-done flag |
| ser_rx_done | input | 1 | Serial receive-done flag |
| src_en | input | 10 | Enable bit for each source, by index |
| src_hi | input | 10 | Priority bit for each source, by index (1 = high) |
| glob_en | input | 1 | Global enable |
| irq_req | output | 1 | A vector is offered (valid) |
| irq_vec | output | 8 | Address of the offered vector |
| irq_ack | input | 1 | The core takes the offered vector (ready) |
| irq_ret | input | 1 | The core returns from its current handler |
| wake | output | 1 | An enabled ext2 to ext5 event is pending |

## Verification
Two functions can act in the same cycle. An edge source's pending flag can be set by a fresh synchronized edge in the very cycle that acceptance of its vector clears it. The bench provokes this by timing a second rising edge on ext2, counting the synchronizer and detector stages, so that the flag is set on the same clock edge as the `irq_ack` handshake. The result is judged after `irq_ret`: the same vector must be offered again, which shows that the new event survived the clear.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NSRC  = 10;
  localparam int NEXT  = 6;
  localparam int IDX_W = $clog2(NSRC);
  localparam int VEC_W = 8;

  // vectors step by 8; the added sources sit in a second bank 16 bytes higher
  function automatic logic [VEC_W-1:0] vec_of(logic [IDX_W-1:0] idx);
    logic [VEC_W-1:0] base;
    base = {1'b0, idx, 3'b011};
    if (idx >= IDX_W'(6)) base = base + 8'd16;
    return base;
  endfunction
endpackage

// File: rtl/irqv_sync.sv
module irqv_sync #(
  parameter int STAGES  = 2,
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic act
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= {STAGES{FALLING}};
    else        sh <= {sh[STAGES-2:0], pin};
  end

  generate
    if (FALLING) begin : g_fall
      assign act = ~sh[STAGES-1];
    end else begin : g_rise
      assign act = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/irqv_pick.sv
module irqv_pick #(
  parameter int N  = 10,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/irqv_nest.sv
module irqv_nest (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic take_hi,
  input  logic ret,
  output logic hi_is,
  output logic lo_is
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_is <= 1'b0;
      lo_is <= 1'b0;
    end else if (take) begin
      if (take_hi) hi_is <= 1'b1;
      else         lo_is <= 1'b1;
    end else if (ret) begin
      if (hi_is) hi_is <= 1'b0;
      else       lo_is <= 1'b0;
    end
  end

  assert_take_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take && take_hi |=> hi_is);
  assert_ret_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ret && !take && hi_is |=> !hi_is && (lo_is == $past(lo_is)));
  assert_ret_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ret && !take && !hi_is |=> !lo_is);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NEXT-1:0]  ext_pin,
  input  logic [1:0]       ext01_edge,
  input  logic [2:0]       tmr_ovf,
  input  logic             ser_tx_done,
  input  logic             ser_rx_done,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NSRC-1:0]  src_hi,
  input  logic             glob_en,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  input  logic             irq_ack,
  input  logic             irq_ret,
  output logic             wake
);
  logic [NEXT-1:0]  ext_act, ext_prev, ext_edge;
  logic [NSRC-1:0]  is_edge, lvl, set_v, clr_v, pend_q, pend_eff;
  logic [NSRC-1:0]  elig, hi_c, lo_c;
  logic             hi_is, lo_is, take;
  logic             hi_found, lo_found;
  logic [IDX_W-1:0] hi_idx, lo_idx;
  logic             offer_v, offer_hi;
  logic [IDX_W-1:0] offer_idx;

  // pin synchronizers; ext0/1/3/5 sense falling, ext2/4 rising
  generate
    for (genvar k = 0; k < NEXT; k++) begin : g_ext
      localparam bit FALL = (k == 0) || (k == 1) || (k == 3) || (k == 5);
      irqv_sync #(.STAGES(SYNC_STAGES), .FALLING(FALL)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin[k]), .act(ext_act[k]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_prev <= '0;
    else        ext_prev <= ext_act;
  end
  assign ext_edge = ext_act & ~ext_prev;

  // map into source index space
  always_comb begin
    is_edge = {4'b1111, 3'b000, ext01_edge[1], 1'b0, ext01_edge[0]};
    lvl     = {4'b0000, tmr_ovf[2], ser_tx_done | ser_rx_done, tmr_ovf[1],
               ext_act[1], tmr_ovf[0], ext_act[0]};
    set_v   = {ext_edge[5:2], 3'b000, ext_edge[1] & ext01_edge[1], 1'b0,
               ext_edge[0] & ext01_edge[0]};
  end

  assign take = offer_v & irq_ack;

  always_comb begin
    clr_v = '0;
    if (take) clr_v[offer_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= is_edge & (set_v | (pend_q & ~clr_v));
  end

  assign pend_eff = (is_edge & pend_q) | (~is_edge & lvl);

  // arbitration under nesting rules
  always_comb begin
    elig = pend_eff & src_en & {NSRC{glob_en}};
    hi_c = elig & src_hi & {NSRC{~hi_is}};
    lo_c = elig & ~src_hi & {NSRC{~hi_is & ~lo_is}};
  end

  irqv_pick #(.N(NSRC)) u_pick_hi (.req(hi_c), .found(hi_found), .idx(hi_idx));
  irqv_pick #(.N(NSRC)) u_pick_lo (.req(lo_c), .found(lo_found), .idx(lo_idx));

  // offer register: held until accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offer_v   <= 1'b0;
      offer_hi  <= 1'b0;
      offer_idx <= '0;
    end else if (take) begin
      offer_v <= 1'b0;
    end else if (!offer_v && (hi_found || lo_found)) begin
      offer_v   <= 1'b1;
      offer_hi  <= hi_found;
      offer_idx <= hi_found ? hi_idx : lo_idx;
    end
  end

  irqv_nest u_nest (
    .clk(clk), .rst_n(rst_n), .take(take), .take_hi(offer_hi),
    .ret(irq_ret), .hi_is(hi_is), .lo_is(lo_is));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake <= 1'b0;
    else        wake <= |(pend_eff[NSRC-1:6] & src_en[NSRC-1:6]);
  end

  assign irq_req = offer_v;
  assign irq_vec = vec_of(offer_idx);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !irq_ack |=> irq_req && $stable(irq_vec));
  assert_no_offer_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> !hi_is);
  assert_lo_only_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) && lo_is |-> offer_hi);
  assert_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(glob_en));

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_chk
      assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_v[i] |=> pend_q[i] || !is_edge[i]);
    end
  endgenerate
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] ext_pin;
  logic [1:0] ext01_edge;
  logic [2:0] tmr_ovf;
  logic       ser_tx_done, ser_rx_done;
  logic [9:0] src_en, src_hi;
  logic       glob_en, irq_req, irq_ack, irq_ret, wake;
  logic [7:0] irq_vec;
  int nchk = 0;
  int nerr = 0;

  localparam logic [5:0] PIN_IDLE = 6'b101011;

  always #2 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext01_edge(ext01_edge),
    .tmr_ovf(tmr_ovf), .ser_tx_done(ser_tx_done), .ser_rx_done(ser_rx_done),
    .src_en(src_en), .src_hi(src_hi), .glob_en(glob_en), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_ret(irq_ret), .wake(wake));

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ext_pin = PIN_IDLE; ext01_edge = 2'b00; tmr_ovf = '0;
    ser_tx_done = 0; ser_rx_done = 0; src_en = '0; src_hi = '0;
    glob_en = 1'b1; irq_ack = 0; irq_ret = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic pulse_ack();
    irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
  endtask

  task automatic pulse_ret();
    irq_ret = 1'b1; cyc(1); irq_ret = 1'b0;
  endtask

  task automatic fire(input int i);
    case (i)
      0: ext_pin[0] = 1'b0;
      1: tmr_ovf[0] = 1'b1;
      2: ext_pin[1] = 1'b0;
      3: tmr_ovf[1] = 1'b1;
      4: ser_rx_done = 1'b1;
      5: tmr_ovf[2] = 1'b1;
      6: ext_pin[2] = 1'b1;
      7: ext_pin[3] = 1'b0;
      8: ext_pin[4] = 1'b1;
      default: ext_pin[5] = 1'b0;
    endcase
  endtask

  function automatic logic [7:0] exp_vec(input int i);
    case (i)
      0: return 8'h03; 1: return 8'h0B; 2: return 8'h13; 3: return 8'h1B;
      4: return 8'h23; 5: return 8'h2B; 6: return 8'h43; 7: return 8'h4B;
      8: return 8'h53; default: return 8'h5B;
    endcase
  endfunction

  task automatic t_reset();
    do_reset();
    check("R13 req after reset", irq_req, 0);
    check("R13 wake after reset", wake, 0);
  endtask

  task automatic t_vectors();
    for (int i = 0; i < 10; i++) begin
      do_reset();
      src_en[i] = 1'b1;
      fire(i);
      cyc(6);
      check($sformatf("R1 vector of source %0d", i), {irq_req, irq_vec}, {1'b1, exp_vec(i)});
    end
  endtask

  task automatic t_order();
    do_reset();
    glob_en = 0;
    src_en[1] = 1; src_en[4] = 1; src_en[7] = 1;
    fire(1); fire(4); fire(7);
    cyc(6);
    glob_en = 1;
    cyc(2);
    check("R2 lowest index first", irq_vec, 8'h0B);
    pulse_ack();
    tmr_ovf[0] = 0;
    pulse_ret();
    cyc(3);
    check("R2 R5 serial before ext3 after return", {irq_req, irq_vec}, {1'b1, 8'h23});
  endtask

  task automatic t_prio();
    do_reset();
    glob_en = 0;
    src_en[1] = 1; src_en[9] = 1; src_hi[9] = 1;
    fire(1); fire(9);
    cyc(6);
    glob_en = 1;
    cyc(2);
    check("R3 high beats low", irq_vec, 8'h5B);
  endtask

  task automatic t_nest();
    do_reset();
    src_en = 10'h3FF;
    fire(3);
    cyc(3);
    check("R4 first low taken", irq_vec, 8'h1B);
    pulse_ack();
    fire(5);
    cyc(4);
    check("R4 low blocked in low service", irq_req, 0);
    src_hi[8] = 1; fire(8);
    cyc(6);
    check("R4 high nests over low", {irq_req, irq_vec}, {1'b1, 8'h53});
    pulse_ack();
    src_hi[0] = 1; fire(0);
    cyc(5);
    check("R4 nothing in high service", irq_req, 0);
    pulse_ret();
    cyc(3);
    check("R5 high unblocked after return", {irq_req, irq_vec}, {1'b1, 8'h03});
  endtask

  task automatic t_edges();
    do_reset();
    src_en[8] = 1;
    ext_pin[4] = 1'b1;
    cyc(3);
    check("R6 no request before sync and detect", irq_req, 0);
    cyc(1);
    check("R6 rising edge on ext4", irq_req, 1);
    pulse_ack(); pulse_ret();
    ext_pin[4] = 1'b0;
    cyc(6);
    check("R6 falling edge ignored on ext4", irq_req, 0);
    do_reset();
    ext01_edge[0] = 1; src_en[0] = 1;
    fire(0);
    cyc(6);
    check("R6 ext0 edge mode", irq_vec, 8'h03);
    pulse_ack(); pulse_ret();
    cyc(4);
    check("R8 edge pending cleared on take", irq_req, 0);
    do_reset();
    src_en[0] = 1;
    fire(0);
    cyc(5);
    pulse_ack(); pulse_ret();
    cyc(3);
    check("R7 level source persists", {irq_req, irq_vec}, {1'b1, 8'h03});
  endtask

  task automatic t_coincide();
    do_reset();
    src_en[6] = 1;
    ext_pin[2] = 1'b1;
    cyc(6);
    check("R8 first ext2 event", irq_vec, 8'h43);
    ext_pin[2] = 1'b0;
    cyc(4);
    ext_pin[2] = 1'b1;
    cyc(2);
    pulse_ack();
    pulse_ret();
    cyc(3);
    check("R8 new edge wins over clear", {irq_req, irq_vec}, {1'b1, 8'h43});
  endtask

  task automatic t_gate();
    do_reset();
    fire(1);
    cyc(4);
    check("R10 disabled source ignored", irq_req, 0);
    src_en[1] = 1;
    cyc(2);
    check("R10 enabled source offered", irq_vec, 8'h0B);
    do_reset();
    glob_en = 0; src_en[7] = 1;
    fire(7);
    cyc(4);
    ext_pin[3] = 1'b1;
    cyc(4);
    check("R10 global enable gates", irq_req, 0);
    glob_en = 1;
    cyc(2);
    check("R10 latched edge requests later", {irq_req, irq_vec}, {1'b1, 8'h4B});
    src_en[9] = 1; src_hi[9] = 1; fire(9);
    cyc(6);
    check("R11 offer held against higher request", irq_vec, 8'h4B);
    pulse_ack();
    cyc(2);
    check("R11 R4 higher offered after take", irq_vec, 8'h5B);
  endtask

  task automatic t_serial();
    do_reset();
    src_en[4] = 1;
    ser_tx_done = 1;
    cyc(3);
    check("R9 transmit flag requests", irq_vec, 8'h23);
    pulse_ack(); pulse_ret();
    cyc(3);
    check("R9 serial not cleared by take", irq_req, 1);
  endtask

  task automatic t_wake();
    do_reset();
    glob_en = 0; src_en[9] = 1;
    check("R12 wake idle", wake, 0);
    fire(9);
    cyc(6);
    check("R12 wake without global enable", {wake, irq_req}, 2'b10);
    src_en[9] = 0;
    cyc(2);
    check("R12 wake needs source enable", wake, 0);
  endtask

  initial begin
    #400000;
    nerr++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    t_reset();
    t_vectors();
    t_order();
    t_prio();
    t_nest();
    t_edges();
    t_coincide();
    t_gate();
    t_serial();
    t_wake();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule